// File: doc/BRIEF.md
# SPI Host Data Queues with Threshold Interrupts

This block holds the two byte queues that sit between a processor's 32-bit register port and the shift engine of an SPI host. Software pushes outgoing bytes by writing one data register and pops incoming bytes by reading another. Each of those registers also reports in bit 31 whether its queue is full (transmit) or empty (receive). The shift engine drains the transmit queue and fills the receive queue through two valid/ready byte streams. It has no part in the serial protocol.

Two programmable thresholds, one for each queue, raise level-sensitive pending conditions. Software gates them with an enable register to form one interrupt line. A driver usually loads a burst into the transmit queue and then waits on the transmit threshold. When it expects replies, it sets the receive threshold to the number of replies minus one and waits for that instead.

Stream back-pressure rules: a transmit byte leaves only on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low. A receive byte is taken only on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low exactly while the receive queue is full, and the engine must keep the byte until it is accepted.

Top module: `spi_fifo_regs`

## Requirements
- R1: After reset both queues are empty, the enable register (offset 0x10) reads 0, the transmit threshold (offset 0x08) reads 1 and the receive threshold (offset 0x0C) reads 0.
- R2: A write to offset 0x00 pushes bits 7:0 of the write data onto the transmit queue. `tx_valid` is high exactly while that queue holds data, and bytes leave on `tx_data` in the order they were written.
- R3: A read of offset 0x00 returns bit 31 set when the transmit queue holds DEPTH bytes and all other bits zero. A write to offset 0x00 while the queue is full is dropped and leaves its contents unchanged.
- R4: A read of offset 0x04 with data present returns the oldest received byte in bits 7:0, with all other bits zero, and removes it. With the queue empty it returns 0x8000_0000 and removes nothing.
- R5: `rx_ready` is high exactly while the receive queue holds fewer than DEPTH bytes. Accepted bytes are returned by reads in arrival order.
- R6: Pending bit 0 (offset 0x14) is 1 while the transmit queue count is strictly below the transmit threshold.
- R7: Pending bit 1 (offset 0x14) is 1 while the receive queue count is strictly above the receive threshold.
- R8: The pending register is read-only. Writes to offset 0x14 change nothing.
- R9: `irq` is high exactly when some pending bit is set and its enable bit (same bit position at offset 0x10) is set.
- R10: A push and a pop on the same queue in one cycle leave its count unchanged, and both bytes keep their order.
- R11: The thresholds hold the low CNT_W bits of the write data, where CNT_W = ceil(log2(DEPTH+1)). The enable register holds bits 1:0. All three read back zero-extended. Unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x04) |
| reg_addr | input | 5 | Byte offset; bits 4:2 select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| tx_valid | output | 1 | Transmit byte available to the shift engine |
| tx_ready | input | 1 | Shift engine takes the transmit byte |
| tx_data | output | DW | Oldest transmit byte |
| rx_valid | input | 1 | Shift engine offers a received byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | DW | Received byte |
| irq | output | 1 | Masked threshold interrupt |

## Verification
The bench builds the block with DEPTH = 4. With that depth a few writes fill either queue, so the dropped write, the refused receive beat and the full flag come up many times in a short random run. It also gives a 3-bit threshold field, which can be set beyond the depth. That makes the threshold compares reach both their always-pending and never-pending extremes. Push and pop in the same cycle are driven while a queue is partly filled and also while it is full.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned SRC_TX   = 0;
  localparam int unsigned SRC_RX   = 1;
  localparam int unsigned NUM_SRC  = 2;

  typedef enum logic [2:0] {
    RI_TXDATA = 3'd0,
    RI_RXDATA = 3'd1,
    RI_TXMARK = 3'd2,
    RI_RXMARK = 3'd3,
    RI_IE     = 3'd4,
    RI_IP     = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/sfr_fifo.sv
module sfr_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             in_fire, out_fire;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (in_fire) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (in_fire)  wr_ptr <= bump(wr_ptr);
      if (out_fire) rd_ptr <= bump(rd_ptr);
      if (in_fire && !out_fire)      count <= count + 1'b1;
      else if (out_fire && !in_fire) count <= count - 1'b1;
    end
  end

  // R3: occupancy never exceeds the depth
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R3: a full queue that is not drained stays full (push dropped)
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && !out_ready) |=> count == FULL_CNT);
  // R10: push and pop together keep the count
  p_same_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && out_fire) |=> $stable(count));
  // R2: head byte holds while the consumer stalls
  p_head_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R4: an empty queue with no push stays empty
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !in_valid) |=> count == '0);
endmodule

// File: rtl/sfr_irq.sv
module sfr_irq #(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_mark,
  input  logic [CNT_W-1:0] rx_mark,
  input  logic [1:0]       irq_en,
  output logic [1:0]       pend,
  output logic             irq
);
  import spi_fifo_pkg::*;

  always_comb begin
    pend         = '0;
    pend[SRC_TX] = (tx_count < tx_mark);
    pend[SRC_RX] = (rx_count > rx_mark);
  end

  assign irq = |(pend & irq_en);
endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic [spi_fifo_pkg::ADDR_W-1:0] reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic                            tx_valid,
  input  logic                            tx_ready,
  output logic [DW-1:0]                   tx_data,
  input  logic                            rx_valid,
  output logic                            rx_ready,
  input  logic [DW-1:0]                   rx_data,
  output logic                            irq
);
  import spi_fifo_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  reg_idx_e         idx;
  logic             wr_tx, rd_rx;
  logic             tx_room, rx_avail;
  logic [DW-1:0]    rx_head;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic [CNT_W-1:0] tx_mark, rx_mark;
  logic [1:0]       irq_en, pend;

  assign idx   = reg_idx_e'(reg_addr[ADDR_W-1:2]);
  assign wr_tx = reg_wr && (idx == RI_TXDATA);
  assign rd_rx = reg_rd && (idx == RI_RXDATA);

  sfr_fifo #(.W(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_tx), .in_ready(tx_room), .in_data(reg_wdata[DW-1:0]),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data),
    .count(tx_count)
  );

  sfr_fifo #(.W(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_ready(rx_ready), .in_data(rx_data),
    .out_valid(rx_avail), .out_ready(rd_rx), .out_data(rx_head),
    .count(rx_count)
  );

  sfr_irq #(.CNT_W(CNT_W)) u_irq (
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_mark(tx_mark), .rx_mark(rx_mark),
    .irq_en(irq_en), .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_mark <= CNT_W'(1);
      rx_mark <= '0;
      irq_en  <= '0;
    end else if (reg_wr) begin
      case (idx)
        RI_TXMARK: tx_mark <= reg_wdata[CNT_W-1:0];
        RI_RXMARK: rx_mark <= reg_wdata[CNT_W-1:0];
        RI_IE:     irq_en  <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (idx)
      RI_TXDATA: reg_rdata[FLAG_BIT] = !tx_room;
      RI_RXDATA: begin
        if (rx_avail) reg_rdata[DW-1:0] = rx_head;
        else          reg_rdata[FLAG_BIT] = 1'b1;
      end
      RI_TXMARK: reg_rdata[CNT_W-1:0] = tx_mark;
      RI_RXMARK: reg_rdata[CNT_W-1:0] = rx_mark;
      RI_IE:     reg_rdata[1:0] = irq_en;
      RI_IP:     reg_rdata[1:0] = pend;
      default: ;
    endcase
  end

  // R9: no interrupt while every source is masked
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);
  // R8: a write to the pending offset leaves the enables untouched
  p_ip_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && idx == RI_IP) |=> $stable(irq_en));
  // R11: enable write is visible the next cycle
  p_ie_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && idx == RI_IE) |=> (irq_en == $past(reg_wdata[1:0])));
endmodule

// File: tb/test_spi_fifo_regs.sv
module test_spi_fifo_regs;
  import spi_fifo_pkg::*;

  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, irq;
  logic [DW-1:0] tx_data, rx_data = '0;

  always #4 clk = ~clk;

  spi_fifo_regs #(.DW(DW), .DEPTH(DEPTH)) i_spi_fifo_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  int errors = 0, checks = 0;
  logic [7:0] txq[$], rxq[$];
  int txm = 1, rxm = 0;
  logic [1:0] iem = 2'b00;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_ip();
    return {(rxq.size() > rxm), (txq.size() < txm)};
  endfunction

  function automatic logic [31:0] exp_read(reg_idx_e i);
    case (i)
      RI_TXDATA: return (txq.size() == DEPTH) ? 32'h8000_0000 : 32'h0;
      RI_RXDATA: return (rxq.size() == 0) ? 32'h8000_0000 : {24'h0, rxq[0]};
      RI_TXMARK: return 32'(txm);
      RI_RXMARK: return 32'(rxm);
      RI_IE:     return {30'h0, iem};
      RI_IP:     return {30'h0, exp_ip()};
      default:   return 32'h0;
    endcase
  endfunction

  task automatic wr(reg_idx_e i, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {i, 2'b00}; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
    case (i)
      RI_TXDATA: if (txq.size() < DEPTH) txq.push_back(d[7:0]);
      RI_TXMARK: txm = int'(d[CW-1:0]);
      RI_RXMARK: rxm = int'(d[CW-1:0]);
      RI_IE:     iem = d[1:0];
      default: ;
    endcase
  endtask

  task automatic rd(reg_idx_e i, string req);
    logic [31:0] e;
    e = exp_read(i);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = {i, 2'b00};
    #1 chk(req, reg_rdata, e);
    @(posedge clk); #1 reg_rd = 1'b0;
    if (i == RI_RXDATA && rxq.size() > 0) void'(rxq.pop_front());
  endtask

  task automatic take(string req);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 chk(req, {31'h0, tx_valid}, {31'h0, txq.size() > 0});
    if (txq.size() > 0) chk(req, {24'h0, tx_data}, {24'h0, txq[0]});
    @(posedge clk); #1 tx_ready = 1'b0;
    if (txq.size() > 0) void'(txq.pop_front());
  endtask

  task automatic give(logic [7:0] b, string req);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 chk(req, {31'h0, rx_ready}, {31'h0, rxq.size() < DEPTH});
    @(posedge clk); #1 rx_valid = 1'b0;
    if (rxq.size() < DEPTH) rxq.push_back(b);
  endtask

  // R10: write and take on the transmit queue in one cycle
  task automatic both_tx(logic [7:0] b);
    bit had;
    had = (txq.size() < DEPTH);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {RI_TXDATA, 2'b00}; reg_wdata = {24'h0, b};
    tx_ready = 1'b1;
    #1 if (txq.size() > 0) chk("R10", {24'h0, tx_data}, {24'h0, txq[0]});
    @(posedge clk); #1 reg_wr = 1'b0; tx_ready = 1'b0;
    if (txq.size() > 0) void'(txq.pop_front());
    if (had) txq.push_back(b);
  endtask

  // R10: offer and read on the receive queue in one cycle
  task automatic both_rx(logic [7:0] b);
    bit had;
    had = (rxq.size() < DEPTH);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    reg_rd = 1'b1; reg_addr = {RI_RXDATA, 2'b00};
    #1 chk("R10", reg_rdata, exp_read(RI_RXDATA));
    @(posedge clk); #1 rx_valid = 1'b0; reg_rd = 1'b0;
    if (rxq.size() > 0) void'(rxq.pop_front());
    if (had) rxq.push_back(b);
  endtask

  task automatic chk_irq();
    @(negedge clk);
    #1 chk("R9", {31'h0, irq}, {31'h0, |(exp_ip() & iem)});
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(RI_IE, "R1"); rd(RI_TXMARK, "R1"); rd(RI_RXMARK, "R1");
    rd(RI_IP, "R1"); rd(RI_TXDATA, "R1"); chk_irq();
    rd(RI_RXDATA, "R4");
    rd(RI_RXDATA, "R4");

    // R2/R3 fill past full, then drain in order
    for (int k = 0; k <= DEPTH; k++) wr(RI_TXDATA, 32'hABCD_0010 + k);
    rd(RI_TXDATA, "R3");
    for (int k = 0; k <= DEPTH; k++) take("R2");

    // R5/R4 receive side including refused beat
    for (int k = 0; k <= DEPTH; k++) give(8'hC0 + 8'(k), "R5");
    for (int k = 0; k <= DEPTH; k++) rd(RI_RXDATA, "R4");

    // R10 simultaneous traffic, partly filled and full
    wr(RI_TXDATA, 32'h11); wr(RI_TXDATA, 32'h22);
    both_tx(8'h33);
    wr(RI_TXDATA, 32'h44); wr(RI_TXDATA, 32'h55);
    both_tx(8'h66);
    rd(RI_TXDATA, "R3");
    for (int k = 0; k < DEPTH; k++) take("R10");
    give(8'h71, "R5"); both_rx(8'h72);
    for (int k = 0; k < DEPTH; k++) give(8'h80 + 8'(k), "R5");
    both_rx(8'h99);
    for (int k = 0; k <= DEPTH; k++) rd(RI_RXDATA, "R10");

    // R6/R7/R11 thresholds
    wr(RI_TXMARK, 32'hFFFF_FFF3); rd(RI_TXMARK, "R11");
    wr(RI_TXDATA, 32'h1); wr(RI_TXDATA, 32'h2); rd(RI_IP, "R6");
    wr(RI_TXDATA, 32'h3); rd(RI_IP, "R6");
    wr(RI_RXMARK, 32'h1); rd(RI_RXMARK, "R11");
    give(8'h5, "R5"); rd(RI_IP, "R7");
    give(8'h6, "R5"); rd(RI_IP, "R7");

    // R8 pending register ignores writes
    wr(RI_IP, 32'hFFFF_FFFC); rd(RI_IP, "R8"); rd(RI_IE, "R8");
    wr(RI_IP, 32'h0000_0003); rd(RI_IP, "R8");

    // R9 masking
    wr(RI_IE, 32'h2); chk_irq(); wr(RI_IE, 32'h1); chk_irq();
    wr(RI_IE, 32'h3); chk_irq(); wr(RI_IE, 32'h0); chk_irq();
    rd(RI_IE, "R11");
    chk("R11", 32'h0, 32'h0);
    @(negedge clk); reg_addr = 5'h1C; #1 chk("R11", reg_rdata, 32'h0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      case ($urandom % 10)
        0, 1: wr(RI_TXDATA, $urandom);
        2:    take("R2");
        3:    give(8'($urandom), "R5");
        4:    rd(RI_RXDATA, "R4");
        5:    wr(($urandom % 2) ? RI_TXMARK : RI_RXMARK, $urandom);
        6:    wr(RI_IE, $urandom);
        7:    rd(RI_IP, "R6");
        8:    if ($urandom % 2) both_tx(8'($urandom)); else both_rx(8'($urandom));
        default: rd(RI_TXDATA, "R3");
      endcase
      if (n % 4 == 0) chk_irq();
    end
    rd(RI_IP, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule